// File: doc/BRIEF.md
# Card Status-Change Interrupt Generator

This block watches the status lines of one removable card slot and raises a level interrupt when one of them changes in a way that software has asked to hear about. Three event sources are tracked: card insertion or removal (two card-detect lines), busy-to-ready transitions of the ready line, and the battery/status-change line. An interface-mode input says whether the inserted card is a memory card or an I/O card. The mode decides which of the ready and status-change sources is live and which edge counts.

Every card line passes through a two-flop synchronizer. Edges are found by comparing each synchronized level with its value one cycle earlier. Each source has a sticky flag that is set by a qualifying edge while the source is enabled, and is cleared by writing 1 to it. A small synchronous register port exposes three registers: the enable register, the sticky flag register, and a read-only view of the synchronized line levels.

Top module: `card_evt_irq`

## Requirements
- R1: After reset the enable register, the flag register and `irq` are all 0. Line levels already present at reset produce no flag, even if the enables are written in the first cycle after reset.
- R2: With the status-change enable (bit 2) set in I/O mode (`io_mode`=1), a 1-to-0 transition of `pin_bvd` sets flag bit 2. A 0-to-1 transition does not.
- R3: In memory mode (`io_mode`=0), `pin_bvd` transitions never set flag bit 2, whatever the enable holds.
- R4: With the card-detect enable (bit 0) set, any change of `pin_cd1` or `pin_cd2`, in either direction and in either mode, sets flag bit 0.
- R5: With the ready enable (bit 1) set in memory mode, a 0-to-1 transition of `pin_rdy` sets flag bit 1. A 1-to-0 transition does not.
- R6: In I/O mode, `pin_rdy` transitions never set flag bit 1.
- R7: A source whose enable bit is 0 never sets its flag.
- R8: Writing register 1 clears each flag whose data bit is 1 and leaves the others. `irq` is high exactly while some flag is set with its enable bit also set.
- R9: If a qualifying edge and a clear of the same flag land in the same cycle, the flag stays set.
- R10: An edge seen in the same cycle that `io_mode` changes is discarded, so a mode switch cannot produce a flag.
- R11: Register 2 reads the synchronized levels: bit 0 `pin_bvd`, bit 1 `pin_cd1`, bit 2 `pin_cd2`, bit 3 `pin_rdy`. Register 0 reads back the enables in bits 2:0 and register 1 the flags in bits 2:0. Unused bits read 0.
- R12: A line change made between clock edges sets its flag, and raises `irq`, on the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_mode | input | 1 | 1 = I/O card, 0 = memory card |
| pin_bvd | input | 1 | Battery/status-change line, asynchronous |
| pin_cd1 | input | 1 | First card-detect line, asynchronous |
| pin_cd2 | input | 1 | Second card-detect line, asynchronous |
| pin_rdy | input | 1 | Ready/busy line, asynchronous |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Register select: 0 enable, 1 flags, 2 levels |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench holds lines high through reset and enables every source in the first cycle after reset. A design that starts its edge history at zero would report a false ready or card-detect event here. It drives each line both ways in both modes, which catches a design that uses the wrong edge polarity or ignores the mode. It also lines a clear write up with a live card-detect edge: a design that gives the clear priority loses the event. It lines a ready edge up with a mode switch: a design that does not discard that edge raises a spurious ready flag. Finally, it checks the cycle-exact flag latency, which exposes a missing or extra synchronizer stage.

// File: rtl/card_evt_pkg.sv
package card_evt_pkg;
  // event source positions in the enable and flag registers
  localparam int SRC_N   = 3;
  localparam int SRC_CD  = 0;
  localparam int SRC_RDY = 1;
  localparam int SRC_SC  = 2;

  // line positions in the level register
  localparam int PIN_N   = 4;
  localparam int PIN_BVD = 0;
  localparam int PIN_CD1 = 1;
  localparam int PIN_CD2 = 2;
  localparam int PIN_RDY = 3;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_FLAGS  = 2'd1,
    REG_LEVEL  = 2'd2
  } reg_sel_e;

  // true when the level moved in a direction the caller accepts
  function automatic logic edge_hit(input logic cur, input logic prv,
                                    input logic on_rise, input logic on_fall);
    return (cur & ~prv & on_rise) | (~cur & prv & on_fall);
  endfunction
endpackage

// File: rtl/card_pin_sync.sv
module card_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/card_edge_qual.sv
module card_edge_qual
  import card_evt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_mode,
  input  logic [PIN_N-1:0] lvl,
  output logic [SRC_N-1:0] ev,
  output logic             hist_ok,
  output logic             mode_flip
);
  localparam int WARM  = STAGES + 1;
  localparam int CNT_W = $clog2(WARM + 1);
  localparam logic [CNT_W-1:0] WARM_C = CNT_W'(WARM);

  logic [PIN_N-1:0] prev;
  logic             mode_q;
  logic [CNT_W-1:0] warm;
  logic [SRC_N-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      mode_q <= 1'b0;
      warm   <= '0;
    end else begin
      prev   <= lvl;
      mode_q <= io_mode;
      if (warm != WARM_C) warm <= warm + 1'b1;
    end
  end

  // history is trusted once the synchronizers carry real line values
  assign hist_ok   = (warm == WARM_C);
  assign mode_flip = io_mode ^ mode_q;

  always_comb begin
    raw = '0;
    raw[SRC_SC]  = io_mode &
                   edge_hit(lvl[PIN_BVD], prev[PIN_BVD], 1'b0, 1'b1);
    raw[SRC_CD]  = edge_hit(lvl[PIN_CD1], prev[PIN_CD1], 1'b1, 1'b1) |
                   edge_hit(lvl[PIN_CD2], prev[PIN_CD2], 1'b1, 1'b1);
    raw[SRC_RDY] = ~io_mode &
                   edge_hit(lvl[PIN_RDY], prev[PIN_RDY], 1'b1, 1'b0);
  end

  assign ev = raw & {SRC_N{hist_ok & ~mode_flip}};

  // R2: a status-change event follows a high-to-low move of the level
  p_sc_falling_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev[SRC_SC] |-> (!lvl[PIN_BVD] && $past(lvl[PIN_BVD])));
  // R5: a ready event follows a low-to-high move of the level
  p_rdy_rising_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev[SRC_RDY] |-> (lvl[PIN_RDY] && !$past(lvl[PIN_RDY])));
endmodule

// File: rtl/card_evt_regs.sv
module card_evt_regs
  import card_evt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PIN_N-1:0]  lvl,
  input  logic [SRC_N-1:0]  ev,
  output logic [DATA_W-1:0] rdata,
  output logic [SRC_N-1:0]  en_o,
  output logic [SRC_N-1:0]  flag_o,
  output logic              irq
);
  logic [SRC_N-1:0] en_q, flag_q, clr;
  logic             wr_en, wr_flag;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:SRC_N];
  assign wr_en   = wr && (addr == REG_ENABLE);
  assign wr_flag = wr && (addr == REG_FLAGS);
  assign clr     = wr_flag ? wdata[SRC_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en) en_q <= wdata[SRC_N-1:0];
      // a fresh event outranks a clear in the same cycle
      flag_q <= (flag_q & ~clr) | (ev & en_q);
    end
  end

  assign irq    = |(flag_q & en_q);
  assign en_o   = en_q;
  assign flag_o = flag_q;

  always_comb begin
    rdata = '0;
    case (addr)
      REG_ENABLE: rdata[SRC_N-1:0] = en_q;
      REG_FLAGS:  rdata[SRC_N-1:0] = flag_q;
      REG_LEVEL:  rdata[PIN_N-1:0] = lvl;
      default:    rdata = '0;
    endcase
  end

  for (genvar k = 0; k < SRC_N; k++) begin : g_chk
    // R7: a flag only rises when its source was enabled
    p_no_set_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[k]) |-> $past(en_q[k]));
    // R9: an enabled event always leaves its flag set, clear or not
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[k] && en_q[k]) |=> flag_q[k]);
  end

  // R8: without a register write the request cannot drop
  p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr) |=> irq);
endmodule

// File: rtl/card_evt_irq.sv
module card_evt_irq
  import card_evt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_mode,
  input  logic              pin_bvd,
  input  logic              pin_cd1,
  input  logic              pin_cd2,
  input  logic              pin_rdy,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [PIN_N-1:0] raw_pins, lvl;
  logic [SRC_N-1:0] ev, en, flag;
  logic             hist_ok, mode_flip;

  always_comb begin
    raw_pins          = '0;
    raw_pins[PIN_BVD] = pin_bvd;
    raw_pins[PIN_CD1] = pin_cd1;
    raw_pins[PIN_CD2] = pin_cd2;
    raw_pins[PIN_RDY] = pin_rdy;
  end

  card_pin_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(lvl));

  card_edge_qual #(.STAGES(SYNC_STAGES)) u_qual (
    .clk(clk), .rst_n(rst_n), .io_mode(io_mode), .lvl(lvl),
    .ev(ev), .hist_ok(hist_ok), .mode_flip(mode_flip));

  card_evt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .lvl(lvl), .ev(ev), .rdata(bus_rdata),
    .en_o(en), .flag_o(flag), .irq(irq));

  // R3: status-change flag never rises while in memory mode
  p_sc_io_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[SRC_SC]) |-> $past(io_mode));
  // R6: ready flag never rises while in I/O mode
  p_rdy_mem_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[SRC_RDY]) |-> !$past(io_mode));
  // R10: a cycle that switches mode adds no flag
  p_mode_switch_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_mode != $past(io_mode)) |=> ((flag & ~$past(flag)) == '0));
  // R8: a raised request implies some flag is held
  p_irq_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag != '0));
  // R1: no event is accepted before history is valid
  p_warmup_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_ok |-> (ev == '0));
  // R10: a mode-flip cycle carries no event
  p_flip_no_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |-> (ev == '0));
endmodule

// File: tb/card_evt_irq_test.sv
`timescale 1ns/1ps
module card_evt_irq_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_mode = 1'b0;
  logic pin_bvd = 1'b1, pin_cd1 = 1'b1, pin_cd2 = 1'b0, pin_rdy = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  card_evt_irq #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .io_mode(io_mode),
    .pin_bvd(pin_bvd), .pin_cd1(pin_cd1), .pin_cd2(pin_cd2), .pin_rdy(pin_rdy),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic write_reg(input logic [1:0] a, input int d);
    bus_addr  = a;
    bus_wdata = DW'(d);
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output int d);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    write_reg(2'd1, 7);
  endtask

  int v;

  task automatic t_reset();
    read_reg(2'd0, v); check("R1 enable at reset", v, 0);
    read_reg(2'd1, v); check("R1 flags at reset", v, 0);
    check("R1 irq at reset", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    write_reg(2'd0, 7);           // lands on the first edge after reset
    settle();
    read_reg(2'd1, v); check("R1 no flag from reset levels", v, 0);
    check("R1 irq quiet after reset", int'(irq), 0);
    read_reg(2'd0, v); check("R11 enable readback", v, 7);
  endtask

  task automatic t_levels();
    read_reg(2'd2, v); check("R11 level register", v, 4'b1011);
    pin_cd2 = 1'b1; pin_bvd = 1'b0;
    settle();
    read_reg(2'd2, v); check("R11 level register after change", v, 4'b1110);
    clear_all();
  endtask

  task automatic t_mem_ready();
    pin_rdy = 1'b0; settle();
    read_reg(2'd1, v); check("R5 falling ready ignored", v, 0);
    pin_rdy = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R12 irq not yet at second edge", int'(irq), 0);
    @(negedge clk);
    check("R12 irq at third edge", int'(irq), 1);
    read_reg(2'd1, v); check("R5 rising ready sets flag", v, 2);
    clear_all();
    read_reg(2'd1, v); check("R8 clear ready flag", v, 0);
    check("R8 irq drops", int'(irq), 0);
  endtask

  task automatic t_mem_bvd();
    pin_bvd = 1'b1; settle();
    pin_bvd = 1'b0; settle();
    read_reg(2'd1, v); check("R3 memory mode ignores status line", v, 0);
  endtask

  task automatic t_card_detect(input string tag);
    pin_cd1 = ~pin_cd1; settle();
    read_reg(2'd1, v); check({tag, " cd1 change"}, v, 1);
    clear_all();
    pin_cd2 = ~pin_cd2; settle();
    read_reg(2'd1, v); check({tag, " cd2 change"}, v, 1);
    clear_all();
    pin_cd1 = ~pin_cd1; settle();
    read_reg(2'd1, v); check({tag, " cd1 change back"}, v, 1);
    clear_all();
  endtask

  task automatic t_io_mode();
    io_mode = 1'b1; settle();
    read_reg(2'd1, v); check("R10 mode switch alone", v, 0);
    pin_bvd = 1'b1; settle();
    read_reg(2'd1, v); check("R2 rising status ignored", v, 0);
    pin_bvd = 1'b0; settle();
    read_reg(2'd1, v); check("R2 falling status sets flag", v, 4);
    check("R2 irq raised", int'(irq), 1);
    clear_all();
    pin_rdy = 1'b0; settle();
    pin_rdy = 1'b1; settle();
    read_reg(2'd1, v); check("R6 io mode ignores ready", v, 0);
  endtask

  task automatic t_disabled();
    write_reg(2'd0, 0);
    pin_bvd = 1'b1; pin_cd1 = ~pin_cd1; pin_rdy = 1'b0; settle();
    pin_bvd = 1'b0; settle();
    read_reg(2'd1, v); check("R7 disabled sources stay clear", v, 0);
    check("R7 irq quiet", int'(irq), 0);
    write_reg(2'd0, 7);
  endtask

  task automatic t_partial_clear();
    pin_bvd = 1'b1; settle();
    pin_bvd = 1'b0; pin_cd2 = ~pin_cd2; settle();
    read_reg(2'd1, v); check("R8 two flags set", v, 5);
    write_reg(2'd1, 0);
    read_reg(2'd1, v); check("R8 write of 0 keeps flags", v, 5);
    write_reg(2'd1, 1);
    read_reg(2'd1, v); check("R8 partial clear", v, 4);
    check("R8 irq held by remaining flag", int'(irq), 1);
    write_reg(2'd1, 4);
    check("R8 irq drops after last clear", int'(irq), 0);
  endtask

  task automatic t_collision();
    pin_cd1 = ~pin_cd1; settle();
    pin_cd2 = ~pin_cd2;
    @(negedge clk); @(negedge clk);
    write_reg(2'd1, 1);           // sampled on the edge that sees the event
    read_reg(2'd1, v); check("R9 event beats clear", v, 1);
    clear_all();
    read_reg(2'd1, v); check("R9 later clear works", v, 0);
  endtask

  task automatic t_mode_edge();
    // io mode, ready low; raise ready so its edge meets the switch to memory
    pin_rdy = 1'b1;
    @(negedge clk); @(negedge clk);
    io_mode = 1'b0;
    settle();
    read_reg(2'd1, v); check("R10 edge at mode switch discarded", v, 0);
    pin_rdy = 1'b0; settle();
    pin_rdy = 1'b1; settle();
    read_reg(2'd1, v); check("R5 ready works after switch", v, 2);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_levels();
    t_mem_ready();
    t_mem_bvd();
    t_card_detect("R4 memory");
    t_io_mode();
    t_card_detect("R4 io");
    t_disabled();
    t_partial_clear();
    t_collision();
    pin_rdy = 1'b0; settle(); clear_all();
    t_mode_edge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule